// File: doc/BRIEF.md
# Hot Region Address Remapper

This block sits on the memory request path and tracks how often each 1 KB region of a small address space is touched. A 4 KB DRAM row holds four such regions. The block keeps a translation table that sends every region number to a physical region slot. At an epoch tick it finds the most frequently used regions and rebuilds the table so that they sit together in a few reserved rows at the top of the space. Accesses to hot data then tend to hit the same open row.

Requests enter on a valid/ready channel. Translated addresses leave on a valid/ready channel one cycle after acceptance, through a single output register. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` drops only while a translated address is waiting and `out_ready` is low. A stalled output holds its address unchanged. After each rebuild, the block lists every change of location on a third valid/ready channel, so that a copy engine can move the data. Each listed move holds steady until `mig_ready` accepts it. The new table takes effect in one cycle, only after the last move has been accepted. Until then every request is translated with the previous table.

Top module: `hmp_remap_top`

## Requirements
- R1: After reset, `out_valid` and `mig_valid` are 0, `req_ready` is 1, and the table is the identity: region r maps to region r.
- R2: A request accepted at a clock edge produces `out_valid` at the next edge. `out_addr[9:0]` equals the request offset, and `out_addr[15:10]` is the table entry for request region `req_addr[15:10]`.
- R3: While `out_valid` is high and `out_ready` is low, `req_ready` is low and `out_addr` stays unchanged.
- R4: Each accepted request counted for its region increments that region's 8-bit counter, which saturates at 255.
- R5: An `epoch_tick` seen while idle starts a rebuild. An `epoch_tick` seen during a rebuild is ignored.
- R6: The rebuild picks 8 regions in rank order by highest count. Equal counts rank the lower region number first, and zero counts still fill the ranks. Rank k is given slot 56+k, so the hot rows are regions 56..63.
- R7: The new table starts from identity. For k = 0..7 in order, the ranked region swaps locations with whichever region currently occupies slot 56+k. The table is therefore always a permutation.
- R8: Requests accepted during the 512 selection cycles that follow the tick are not counted. Requests accepted at any time during a rebuild are translated with the old table.
- R9: All counters clear when selection ends, so each epoch ranks only the accesses made since the previous selection ended. The tick cycle itself counts toward the current epoch.
- R10: For each region whose location changes, in ascending region order, one move is offered: `mig_src` is the old location and `mig_dst` is the new one. It holds until `mig_ready` is high. Unchanged regions produce nothing.
- R11: The new table replaces the old one in a single cycle, after the final move is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request address present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 16 | Region number [15:10] and offset [9:0] |
| epoch_tick | input | 1 | One-cycle pulse asking for a table rebuild |
| out_valid | output | 1 | Translated address present |
| out_ready | input | 1 | Consumer takes the translated address |
| out_addr | output | 16 | Translated address |
| mig_valid | output | 1 | Region move offered |
| mig_ready | input | 1 | Copy engine takes the move |
| mig_src | output | 6 | Region's location under the old table |
| mig_dst | output | 6 | Region's location under the new table |

## Verification
The properties assume that reset is applied before the first request. They also assume that `out_ready` and `mig_ready` may take any value in any cycle, so the hold rules must survive arbitrary stalls. The offset and latency properties compare the cycle after acceptance with the accepted request, and therefore ask nothing of the requester's address once it is taken. The stimulus holds each request until it is accepted. It stalls both outputs in fixed patterns, sends requests only inside the selection window or while moves are stalled during a rebuild, and pulses the tick while a rebuild is already running.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_INIT,
    ST_BUILD,
    ST_MIGR,
    ST_SWAP
  } remap_state_e;
endpackage

// File: rtl/hmp_count_bank.sv
module hmp_count_bank #(
  parameter int NUM_REG = 64,
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM_REG];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_cnt
    logic hit;
    assign hit = inc_en && (inc_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
      end else if (clr_all) begin
        cnt_q[g] <= '0;
      end else if (hit && (cnt_q[g] != CNT_MAX)) begin
        cnt_q[g] <= cnt_q[g] + 1'b1;
      end
    end
  end

  assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/hmp_topn_scan.sv
module hmp_topn_scan #(
  parameter int NUM_REG  = 64,
  parameter int CNT_W    = 8,
  parameter int NUM_SLOT = 8,
  parameter int IDX_W    = 6,
  parameter int RANK_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [CNT_W-1:0]  rd_cnt,
  output logic              pick_we,
  output logic [RANK_W-1:0] pick_rank,
  output logic [IDX_W-1:0]  pick_idx,
  output logic              done
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_REG - 1);
  localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_SLOT - 1);

  logic               busy_q;
  logic [IDX_W-1:0]   idx_q;
  logic [RANK_W-1:0]  rank_q;
  logic [NUM_REG-1:0] taken_q;
  logic               best_vld_q;
  logic [CNT_W-1:0]   best_cnt_q;
  logic [IDX_W-1:0]   best_idx_q;

  logic               better;
  logic [IDX_W-1:0]   win_idx;
  logic               pass_end;

  always_comb begin
    better   = busy_q && !taken_q[idx_q] && (!best_vld_q || (rd_cnt > best_cnt_q));
    win_idx  = better ? idx_q : best_idx_q;
    pass_end = busy_q && (idx_q == LAST_IDX);
  end

  assign rd_idx    = idx_q;
  assign pick_we   = pass_end;
  assign pick_rank = rank_q;
  assign pick_idx  = win_idx;
  assign done      = pass_end && (rank_q == LAST_RANK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      rank_q     <= '0;
      taken_q    <= '0;
      best_vld_q <= 1'b0;
      best_cnt_q <= '0;
      best_idx_q <= '0;
    end else if (start) begin
      busy_q     <= 1'b1;
      idx_q      <= '0;
      rank_q     <= '0;
      taken_q    <= '0;
      best_vld_q <= 1'b0;
      best_cnt_q <= '0;
      best_idx_q <= '0;
    end else if (busy_q) begin
      if (pass_end) begin
        taken_q[win_idx] <= 1'b1;
        best_vld_q       <= 1'b0;
        best_cnt_q       <= '0;
        idx_q            <= '0;
        rank_q           <= rank_q + 1'b1;
        if (rank_q == LAST_RANK) begin
          busy_q <= 1'b0;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
        if (better) begin
          best_vld_q <= 1'b1;
          best_cnt_q <= rd_cnt;
          best_idx_q <= idx_q;
        end
      end
    end
  end
endmodule

// File: rtl/hmp_perm_build.sv
module hmp_perm_build #(
  parameter int NUM_REG  = 64,
  parameter int NUM_SLOT = 8,
  parameter int HOT_BASE = 56,
  parameter int IDX_W    = 6,
  parameter int RANK_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pick_we,
  input  logic [RANK_W-1:0]        pick_rank,
  input  logic [IDX_W-1:0]         pick_idx,
  input  logic                     init,
  input  logic                     step_en,
  input  logic [RANK_W-1:0]        step_rank,
  output logic [NUM_REG*IDX_W-1:0] nxt_map_flat
);
  logic [IDX_W-1:0] hot_list_q [NUM_SLOT];
  logic [IDX_W-1:0] fwd_q      [NUM_REG];
  logic [IDX_W-1:0] inv_q      [NUM_REG];

  logic [IDX_W-1:0] a_reg;
  logic [IDX_W-1:0] t_slot;
  logic [IDX_W-1:0] a_loc;
  logic [IDX_W-1:0] b_reg;

  always_comb begin
    a_reg  = hot_list_q[step_rank];
    t_slot = IDX_W'(HOT_BASE) + IDX_W'(step_rank);
    a_loc  = fwd_q[a_reg];
    b_reg  = inv_q[t_slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOT; i++) begin
        hot_list_q[i] <= '0;
      end
    end else if (pick_we) begin
      hot_list_q[pick_rank] <= pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REG; r++) begin
        fwd_q[r] <= IDX_W'(r);
        inv_q[r] <= IDX_W'(r);
      end
    end else if (init) begin
      for (int r = 0; r < NUM_REG; r++) begin
        fwd_q[r] <= IDX_W'(r);
        inv_q[r] <= IDX_W'(r);
      end
    end else if (step_en) begin
      fwd_q[b_reg]  <= a_loc;
      fwd_q[a_reg]  <= t_slot;
      inv_q[a_loc]  <= b_reg;
      inv_q[t_slot] <= a_reg;
    end
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_flat
    assign nxt_map_flat[g*IDX_W +: IDX_W] = fwd_q[g];
  end
endmodule

// File: rtl/hmp_remap_top.sv
module hmp_remap_top
  import hmp_pkg::*;
#(
  parameter int  NUM_REG      = 64,
  parameter int  CNT_W        = 8,
  parameter int  OFF_W        = 10,
  parameter int  REGS_PER_ROW = 4,
  parameter int  HOT_ROWS     = 2,
  localparam int REG_W        = $clog2(NUM_REG),
  localparam int ADDR_W       = REG_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              epoch_tick,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              mig_valid,
  input  logic              mig_ready,
  output logic [REG_W-1:0]  mig_src,
  output logic [REG_W-1:0]  mig_dst
);
  localparam int NUM_SLOT = REGS_PER_ROW * HOT_ROWS;
  localparam int HOT_BASE = NUM_REG - NUM_SLOT;
  localparam int RANK_W   = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;
  localparam logic [REG_W-1:0]  LAST_REG  = REG_W'(NUM_REG - 1);
  localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_SLOT - 1);

  remap_state_e state_q, state_d;

  logic [REG_W-1:0]  act_map_q [NUM_REG];
  logic [REG_W-1:0]  mig_idx_q;
  logic [RANK_W-1:0] step_q;
  logic              out_valid_q;
  logic [ADDR_W-1:0] out_addr_q;

  logic              acc;
  logic [REG_W-1:0]  req_reg;
  logic [OFF_W-1:0]  req_off;
  logic              scan_start;
  logic              scan_done;
  logic              cnt_inc;
  logic [REG_W-1:0]  cnt_rd_idx;
  logic [CNT_W-1:0]  cnt_rd_val;
  logic              pick_we;
  logic [RANK_W-1:0] pick_rank;
  logic [REG_W-1:0]  pick_idx;
  logic [NUM_REG*REG_W-1:0] nxt_map_flat;
  logic [REG_W-1:0]  nxt_at_mig;
  logic              mig_diff;
  logic              mig_adv;

  assign req_reg    = req_addr[ADDR_W-1:OFF_W];
  assign req_off    = req_addr[OFF_W-1:0];
  assign req_ready  = !out_valid_q || out_ready;
  assign acc        = req_valid && req_ready;
  assign scan_start = (state_q == ST_IDLE) && epoch_tick;
  assign cnt_inc    = acc && (state_q != ST_SCAN);

  assign nxt_at_mig = nxt_map_flat[mig_idx_q*REG_W +: REG_W];
  assign mig_diff   = nxt_at_mig != act_map_q[mig_idx_q];
  assign mig_adv    = (state_q == ST_MIGR) && (!mig_diff || mig_ready);

  assign mig_valid  = (state_q == ST_MIGR) && mig_diff;
  assign mig_src    = act_map_q[mig_idx_q];
  assign mig_dst    = nxt_at_mig;
  assign out_valid  = out_valid_q;
  assign out_addr   = out_addr_q;

  hmp_count_bank #(
    .NUM_REG (NUM_REG),
    .CNT_W   (CNT_W),
    .IDX_W   (REG_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (cnt_inc),
    .inc_idx (req_reg),
    .clr_all (scan_done),
    .rd_idx  (cnt_rd_idx),
    .rd_cnt  (cnt_rd_val)
  );

  hmp_topn_scan #(
    .NUM_REG  (NUM_REG),
    .CNT_W    (CNT_W),
    .NUM_SLOT (NUM_SLOT),
    .IDX_W    (REG_W),
    .RANK_W   (RANK_W)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (scan_start),
    .rd_idx    (cnt_rd_idx),
    .rd_cnt    (cnt_rd_val),
    .pick_we   (pick_we),
    .pick_rank (pick_rank),
    .pick_idx  (pick_idx),
    .done      (scan_done)
  );

  hmp_perm_build #(
    .NUM_REG  (NUM_REG),
    .NUM_SLOT (NUM_SLOT),
    .HOT_BASE (HOT_BASE),
    .IDX_W    (REG_W),
    .RANK_W   (RANK_W)
  ) u_perm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pick_we      (pick_we),
    .pick_rank    (pick_rank),
    .pick_idx     (pick_idx),
    .init         (state_q == ST_INIT),
    .step_en      (state_q == ST_BUILD),
    .step_rank    (step_q),
    .nxt_map_flat (nxt_map_flat)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (epoch_tick) state_d = ST_SCAN;
      ST_SCAN:  if (scan_done) state_d = ST_INIT;
      ST_INIT:  state_d = ST_BUILD;
      ST_BUILD: if (step_q == LAST_RANK) state_d = ST_MIGR;
      ST_MIGR:  if (mig_adv && (mig_idx_q == LAST_REG)) state_d = ST_SWAP;
      ST_SWAP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      mig_idx_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_INIT) begin
        step_q <= '0;
      end else if (state_q == ST_BUILD) begin
        step_q <= step_q + 1'b1;
      end
      if (state_q == ST_BUILD) begin
        mig_idx_q <= '0;
      end else if (mig_adv) begin
        mig_idx_q <= mig_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REG; r++) begin
        act_map_q[r] <= REG_W'(r);
      end
    end else if (state_q == ST_SWAP) begin
      for (int r = 0; r < NUM_REG; r++) begin
        act_map_q[r] <= nxt_map_flat[r*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_addr_q  <= '0;
    end else if (req_ready) begin
      out_valid_q <= req_valid;
      if (req_valid) begin
        out_addr_q <= {act_map_q[req_reg], req_off};
      end
    end
  end
endmodule

// File: rtl/hmp_remap_checker.sv
module hmp_remap_checker #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 10,
  parameter int REG_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              mig_valid,
  input logic              mig_ready,
  input logic [REG_W-1:0]  mig_src,
  input logic [REG_W-1:0]  mig_dst
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);

  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (out_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])));

  p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  p_hold_mig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_src) && $stable(mig_dst)));

  p_real_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> (mig_src != mig_dst));
endmodule

bind hmp_remap_top hmp_remap_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .REG_W  (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .mig_valid (mig_valid),
  .mig_ready (mig_ready),
  .mig_src   (mig_src),
  .mig_dst   (mig_dst)
);

// File: tb/hmp_remap_top_bench.sv
module hmp_remap_top_bench;
  localparam int NR   = 64;
  localparam int OFFW = 10;
  localparam int RW   = 6;
  localparam int AW   = 16;
  localparam int NS   = 8;
  localparam int HB   = 56;
  localparam int CMAX = 255;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          epoch_tick;
  logic          out_valid;
  logic          out_ready;
  logic [AW-1:0] out_addr;
  logic          mig_valid;
  logic          mig_ready;
  logic [RW-1:0] mig_src;
  logic [RW-1:0] mig_dst;

  hmp_remap_top u_hmp_remap_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .epoch_tick (epoch_tick),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .mig_valid  (mig_valid),
    .mig_ready  (mig_ready),
    .mig_src    (mig_src),
    .mig_dst    (mig_dst)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mdl_cnt [NR];
  int mdl_fwd [NR];
  int mdl_nxt [NR];
  logic [AW-1:0]   exp_out [$];
  logic [2*RW-1:0] exp_mig [$];
  bit busy = 0;
  int ep_cyc = 0;
  bit mdl_ov = 0;
  bit hold_prev = 0;
  logic [AW-1:0] addr_prev = '0;
  bit mon_on = 0;
  int oready_mode = 0;
  int mready_mode = 0;
  string tag = "R1";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference rebuild: top-N by count (ties to lower index), swaps from identity
  task automatic model_epoch();
    bit taken [NR];
    int hot [NS];
    int inv [NR];
    for (int r = 0; r < NR; r++) taken[r] = 0;
    for (int k = 0; k < NS; k++) begin
      int best = -1;
      for (int r = 0; r < NR; r++)
        if (!taken[r] && (best < 0 || mdl_cnt[r] > mdl_cnt[best])) best = r;
      hot[k] = best;
      taken[best] = 1;
    end
    for (int r = 0; r < NR; r++) begin
      mdl_nxt[r] = r;
      inv[r] = r;
    end
    for (int k = 0; k < NS; k++) begin
      int a = hot[k];
      int t = HB + k;
      int la = mdl_nxt[a];
      int b = inv[t];
      mdl_nxt[b] = la;
      mdl_nxt[a] = t;
      inv[la] = b;
      inv[t] = a;
    end
    for (int r = 0; r < NR; r++)
      if (mdl_nxt[r] != mdl_fwd[r]) exp_mig.push_back({RW'(mdl_fwd[r]), RW'(mdl_nxt[r])});
    for (int r = 0; r < NR; r++) mdl_cnt[r] = 0;
  endtask

  // Monitor and reference model, sampled 1 ns before each rising edge
  initial begin : monitor
    forever begin
      @(negedge clk);
      #4;
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
      if (mon_on) begin
        bit acc;
        check(out_valid === mdl_ov, "R3", "out_valid", out_valid, mdl_ov);
        if (hold_prev) check(out_addr === addr_prev, "R3", "stalled out_addr", out_addr, addr_prev);
        if (out_valid && out_ready) begin
          if (exp_out.size() == 0) check(0, "R2", "unexpected output", out_addr, 0);
          else begin
            logic [AW-1:0] e;
            e = exp_out.pop_front();
            check(out_addr === e, tag, "translated address", out_addr, e);
          end
        end
        hold_prev = out_valid && !out_ready;
        addr_prev = out_addr;
        acc = req_valid && req_ready;
        mdl_ov = acc || (out_valid && !out_ready);
        if (acc) begin
          int rg;
          rg = int'(req_addr[AW-1:OFFW]);
          exp_out.push_back({RW'(mdl_fwd[rg]), req_addr[OFFW-1:0]});
          if (!busy || (cyc - ep_cyc) > 512)
            if (mdl_cnt[rg] < CMAX) mdl_cnt[rg]++;
        end
        if (epoch_tick && !busy) begin
          model_epoch();
          busy = 1;
          ep_cyc = cyc;
        end
        if (mig_valid && mig_ready) begin
          if (exp_mig.size() == 0)
            check(0, "R5", "unexpected move (R10)", {mig_src, mig_dst}, 0);
          else begin
            logic [2*RW-1:0] m;
            m = exp_mig.pop_front();
            check({mig_src, mig_dst} === m, "R10", "move src/dst", {mig_src, mig_dst}, m);
          end
        end
      end
    end
  end

  initial begin : ready_drive
    forever begin
      @(negedge clk);
      out_ready = (oready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      case (mready_mode)
        0: mig_ready = 1'b1;
        1: mig_ready = 1'b0;
        default: mig_ready = ((cyc % 4) != 1);
      endcase
    end
  end

  task automatic send(int rg, int off);
    bit got;
    req_valid = 1'b1;
    req_addr = {RW'(rg), OFFW'(off)};
    do begin
      #4;
      got = req_ready;
      @(negedge clk);
    end while (!got);
    req_valid = 1'b0;
  endtask

  task automatic send_n(int rg, int n);
    for (int i = 0; i < n; i++) send(rg, (i * 7) % 1024);
  endtask

  task automatic pulse_epoch();
    epoch_tick = 1'b1;
    @(negedge clk);
    epoch_tick = 1'b0;
  endtask

  task automatic wait_rebuild();
    while (!(((cyc - ep_cyc) >= 600) && (exp_mig.size() == 0))) @(negedge clk);
    repeat (80) @(negedge clk);
    for (int r = 0; r < NR; r++) mdl_fwd[r] = mdl_nxt[r];
    busy = 0;
  endtask

  task automatic sweep();
    for (int r = 0; r < NR; r++) send(r, (r * 13 + 5) % 1024);
    repeat (4) @(negedge clk);
  endtask

  initial begin : stim
    for (int r = 0; r < NR; r++) begin
      mdl_cnt[r] = 0;
      mdl_fwd[r] = r;
      mdl_nxt[r] = r;
    end
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    epoch_tick = 1'b0;
    out_ready = 1'b1;
    mig_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #4;
    check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(mig_valid === 1'b0, "R1", "mig_valid after reset", mig_valid, 0);
    check(req_ready === 1'b1, "R1", "req_ready after reset", req_ready, 1);
    @(negedge clk);
    mon_on = 1;

    tag = "R1";  // identity table
    sweep();

    tag = "R3";  // counting under output back-pressure (R4)
    oready_mode = 1;
    send_n(10, 20);
    send_n(20, 15);
    send_n(30, 15);
    send_n(57, 12);
    send_n(2, 5);
    oready_mode = 0;
    repeat (4) @(negedge clk);

    pulse_epoch();
    tag = "R8";  // old table, not counted during selection
    send_n(50, 30);
    repeat (20) @(negedge clk);
    pulse_epoch();  // R5: ignored while rebuilding
    wait_rebuild();
    tag = "R6";
    sweep();

    tag = "R4";  // saturation: 300 and 260 both clip to 255, lower region ranks first
    send_n(45, 300);
    send_n(40, 260);
    send_n(1, 3);
    mready_mode = 1;
    pulse_epoch();
    while ((cyc - ep_cyc) < 600) @(negedge clk);
    tag = "R11";  // moves stalled: table must still be the old one
    send_n(45, 20);
    repeat (4) @(negedge clk);
    mready_mode = 2;
    wait_rebuild();
    mready_mode = 0;
    tag = "R7";
    sweep();

    tag = "R9";  // counters were cleared: region 40 history must not win
    send_n(9, 4);
    pulse_epoch();
    wait_rebuild();
    sweep();

    repeat (6) @(negedge clk);
    check(exp_out.size() == 0, "R2", "outputs outstanding", exp_out.size(), 0);
    check(exp_mig.size() == 0, "R10", "moves outstanding", exp_mig.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule